// File: doc/BRIEF.md
# Serial ADC Frame Sequencer (host side)

This block drives a dual-channel 12-bit serial ADC from the host end. A client asks for one operation over a request/acknowledge handshake. The block then lowers chip select and issues a divided serial clock for exactly the number of clock periods that operation needs, samples the two data lines, and returns two 12-bit results with a one-cycle strobe. The converter's power mode is changed only by cutting a frame short, so the block keeps its own copy of the converter's power state. Any read that arrives while the converter is asleep gets a wake-up dummy frame and a settling wait before it.

There are four operations: a 14-clock single read, a 16-clock single read, a 32-clock dual read, and a 4-clock power-down frame. Between frames, chip select stays high for at least a quiet time. After a wake-up dummy frame it stays high for at least the wake time. The serial clock divide, the quiet time and the wake time are parameters.

The controller states are IDLE (waiting for a request), WAKE (dummy frame running), SETTLE (wake wait), FRAME (requested frame running) and QUIET (gap after a frame). The transitions are:
- IDLE to WAKE on a read request while asleep.
- IDLE to FRAME on any other request.
- WAKE to SETTLE at the end of the dummy frame.
- SETTLE to FRAME when the wake count expires.
- FRAME to QUIET at the end of the frame.
- QUIET to IDLE when the quiet count expires.

Top module: `adc_frame_seq`

## Requirements
- R1: While reset is held, the outputs are: cs_n=1, sclk=1, busy=0, req_ack=0, res_valid=0, pwr_mode=00.
- R2: With cs_n low, sclk shows this many falling edges: 14 for op 00, 16 for op 01, 32 for op 10 and 4 for op 11 (power-down). A wake-up dummy frame shows 16.
- R3: sclk is high whenever cs_n is high. In a frame, the first sclk fall comes SCLK_HALF cycles after cs_n falls. Later falls are 2*SCLK_HALF cycles apart.
- R4: For ops 00 and 01, data is sampled on sclk rising edges. res_a takes line A and res_b takes line B, from clocks 3 to 14, MSB first. Clocks 1, 2, 15 and 16 are ignored.
- R5: For op 10, res_a is line A on clocks 3 to 14 and res_b is line A on clocks 19 to 30, both MSB first. Line B is ignored.
- R6: res_valid is a one-cycle pulse for each read frame, one cycle after cs_n rises. Power-down frames and dummy frames give no pulse.
- R7: pwr_mode is 00 when awake, 01 in partial power-down and 10 in full power-down. A power-down frame moves it from 00 to 01, from 01 to 10, and from 10 to 10.
- R8: A read requested while pwr_mode is not 00 first runs a 16-clock dummy frame that gives no result. Chip select then stays high for at least WAKE_CYC cycles before the read frame, and pwr_mode becomes 00.
- R9: Between any two frames, cs_n stays high for at least QUIET_CYC cycles.
- R10: req_ack equals req_valid when busy is low, and is 0 when busy is high. busy rises the cycle after a request is accepted and stays high until the quiet time ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 2 | Operation code (00 read14, 01 read16, 10 dual, 11 power-down) |
| req_ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | Sequencer occupied |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Converter serial clock |
| sdata_a | input | 1 | Converter data line A |
| sdata_b | input | 1 | Converter data line B |
| res_valid | output | 1 | Result strobe |
| res_a | output | 12 | First result |
| res_b | output | 12 | Second result |
| pwr_mode | output | 2 | Tracked converter power state |

## Verification
Two pairs of events can land in the same cycle. First, the result strobe appears in the cycle after chip select rises, which is the first cycle of the quiet count. Second, a new request can arrive in the very cycle that the quiet or wake count expires. The bench issues its next request as soon as the previous frame ends and holds req_valid high through the whole busy period. It then checks that no acknowledge appears while busy, that the measured chip-select-high gap before each frame meets the quiet or wake minimum, and that every strobed result still matches the scoreboard entry queued for it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        OP_RD14 = 2'b00,
        OP_RD16 = 2'b01,
        OP_DUAL = 2'b10,
        OP_PDN  = 2'b11
    } seq_op_e;

    typedef enum logic [1:0] {
        PW_AWAKE   = 2'b00,
        PW_PARTIAL = 2'b01,
        PW_FULL    = 2'b10
    } pwr_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_SETTLE,
        ST_FRAME,
        ST_QUIET
    } seq_st_e;

    localparam int LEN_W     = 6;
    localparam int DUMMY_LEN = 16;
    localparam int PDN_LEN   = 4;

    function automatic logic [LEN_W-1:0] frame_len(seq_op_e op);
        unique case (op)
            OP_RD14: return LEN_W'(14);
            OP_RD16: return LEN_W'(16);
            OP_DUAL: return LEN_W'(32);
            OP_PDN:  return LEN_W'(PDN_LEN);
        endcase
    endfunction
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int SCLK_HALF = 2,
    parameter int LENW      = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [LENW-1:0] len,
    output logic            sclk,
    output logic            active,
    output logic            rise,
    output logic            done
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PER = 2 * SCLK_HALF;
    localparam int PW  = (PER > 1) ? $clog2(PER) : 1;

    logic [PW-1:0]   ph;
    logic [LENW-1:0] cnt;
    logic [LENW-1:0] len_q;
    logic            wrap;

    assign wrap = active && (ph == PW'(PER - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            ph     <= '0;
            cnt    <= '0;
            len_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            ph     <= '0;
            cnt    <= '0;
            len_q  <= len;
        end else if (active) begin
            if (wrap) begin
                ph  <= '0;
                cnt <= cnt + 1'b1;
                if (cnt == len_q - LENW'(1))
                    active <= 1'b0;
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    // high half first (setup after select), then low half; rise at period end
    assign sclk = !active || (ph < PW'(SCLK_HALF));
    assign rise = wrap;
    assign done = wrap && (cnt == len_q - LENW'(1));
endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift
    import adc_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        rise,
    input  logic        fin,
    input  logic        keep,
    input  seq_op_e     mode,
    input  logic        sda,
    input  logic        sdb,
    output logic [11:0] res_a,
    output logic [11:0] res_b,
    output logic        res_valid
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [12:0] sha;
    logic [12:0] shb;
    logic [13:0] nxa;
    logic [13:0] nxb;
    logic [5:0]  idx;
    logic [11:0] first_q;

    assign nxa = {sha, sda};
    assign nxb = {shb, sdb};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sha       <= '0;
            shb       <= '0;
            idx       <= '0;
            first_q   <= '0;
            res_a     <= '0;
            res_b     <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (clr) begin
                sha <= '0;
                shb <= '0;
                idx <= '0;
            end else if (rise) begin
                sha <= nxa[12:0];
                shb <= nxb[12:0];
                idx <= idx + 1'b1;
                // 16th clock: window holds clocks 3..14 of the first word
                if (idx == 6'd15)
                    first_q <= nxa[13:2];
                if (fin && keep) begin
                    res_valid <= 1'b1;
                    unique case (mode)
                        OP_RD14: begin
                            res_a <= nxa[11:0];
                            res_b <= nxb[11:0];
                        end
                        OP_RD16: begin
                            res_a <= nxa[13:2];
                            res_b <= nxb[13:2];
                        end
                        OP_DUAL: begin
                            res_a <= first_q;
                            res_b <= nxa[13:2];
                        end
                        OP_PDN: begin
                            res_valid <= 1'b0;
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/adc_pwr_track.sv
module adc_pwr_track
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pd_done,
    input  logic wake_done,
    output pwr_e mode,
    output logic asleep
);
    timeunit 1ns;
    timeprecision 1ps;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= PW_AWAKE;
        end else if (wake_done) begin
            mode <= PW_AWAKE;
        end else if (pd_done) begin
            unique case (mode)
                PW_AWAKE:   mode <= PW_PARTIAL;
                PW_PARTIAL: mode <= PW_FULL;
                PW_FULL:    mode <= PW_FULL;
                default:    mode <= PW_FULL;
            endcase
        end
    end

    assign asleep = (mode != PW_AWAKE);
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_seq_pkg::*;
#(
    parameter int SCLK_HALF = 2,
    parameter int QUIET_CYC = 4,
    parameter int WAKE_CYC  = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    output logic        req_ack,
    output logic        busy,
    output logic        cs_n,
    output logic        sclk,
    input  logic        sdata_a,
    input  logic        sdata_b,
    output logic        res_valid,
    output logic [11:0] res_a,
    output logic [11:0] res_b,
    output logic [1:0]  pwr_mode
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TMAX = (QUIET_CYC > WAKE_CYC) ? QUIET_CYC : WAKE_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    seq_st_e          state, state_nxt;
    seq_op_e          op_q;
    seq_op_e          op_in;
    logic [TW-1:0]    tcnt;
    logic             start;
    logic [LEN_W-1:0] start_len;
    logic             gen_active, gen_rise, gen_done;
    logic             asleep;
    pwr_e             pmode;
    logic             keep;
    logic             pd_done, wake_done;

    assign op_in = seq_op_e'(req_op);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // operation latch and shared wait counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_RD14;
            tcnt <= '0;
        end else begin
            if (state == ST_IDLE && req_valid)
                op_q <= op_in;
            if (state_nxt != state) tcnt <= '0;
            else                    tcnt <= tcnt + 1'b1;
        end
    end

    // next state and frame launch
    always_comb begin
        state_nxt = state;
        start     = 1'b0;
        start_len = frame_len(op_q);
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    start = 1'b1;
                    if (op_in != OP_PDN && asleep) begin
                        start_len = LEN_W'(DUMMY_LEN);
                        state_nxt = ST_WAKE;
                    end else begin
                        start_len = frame_len(op_in);
                        state_nxt = ST_FRAME;
                    end
                end
            end
            ST_WAKE: begin
                if (gen_done) state_nxt = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tcnt == TW'(WAKE_CYC - 1)) begin
                    start     = 1'b1;
                    start_len = frame_len(op_q);
                    state_nxt = ST_FRAME;
                end
            end
            ST_FRAME: begin
                if (gen_done) state_nxt = ST_QUIET;
            end
            ST_QUIET: begin
                if (tcnt == TW'(QUIET_CYC - 1)) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ack   = (state == ST_IDLE) && req_valid;
        busy      = (state != ST_IDLE);
        cs_n      = !gen_active;
        keep      = (state == ST_FRAME) && (op_q != OP_PDN);
        pd_done   = gen_done && (state == ST_FRAME) && (op_q == OP_PDN);
        wake_done = gen_done && (state == ST_WAKE);
        pwr_mode  = pmode;
    end

    adc_sclk_gen #(
        .SCLK_HALF (SCLK_HALF),
        .LENW      (LEN_W)
    ) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .len    (start_len),
        .sclk   (sclk),
        .active (gen_active),
        .rise   (gen_rise),
        .done   (gen_done)
    );

    adc_rx_shift u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start),
        .rise      (gen_rise),
        .fin       (gen_done),
        .keep      (keep),
        .mode      (op_q),
        .sda       (sdata_a),
        .sdb       (sdata_b),
        .res_a     (res_a),
        .res_b     (res_b),
        .res_valid (res_valid)
    );

    adc_pwr_track u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_done   (pd_done),
        .wake_done (wake_done),
        .mode      (pmode),
        .asleep    (asleep)
    );
endmodule

// File: rtl/adc_frame_seq_chk.sv
module adc_frame_seq_chk #(
    parameter int QUIET_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ack,
    input logic       busy,
    input logic       cs_n,
    input logic       sclk,
    input logic       res_valid,
    input logic [1:0] pwr_mode
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int GW = $clog2(QUIET_CYC + 2);
    localparam logic [GW-1:0] GMAX = GW'(QUIET_CYC + 1);

    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (!rst_n)     gap <= GMAX;
        else if (!cs_n) gap <= '0;
        else if (gap != GMAX) gap <= gap + 1'b1;
    end

    a_r10_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> !busy);

    a_r10_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r6_valid_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (cs_n && $past(cs_n) == 1'b0));

    a_r9_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (gap >= GW'(QUIET_CYC)));

    a_r7_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_mode != 2'b11);

    a_r8_read_awake: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (pwr_mode == 2'b00));
endmodule

bind adc_frame_seq adc_frame_seq_chk #(.QUIET_CYC(QUIET_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ack   (req_ack),
    .busy      (busy),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .res_valid (res_valid),
    .pwr_mode  (pwr_mode)
);

// File: tb/adc_frame_seq_bench.sv
module adc_frame_seq_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int HALF = 2;
    localparam int QC   = 4;
    localparam int WC   = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic        sda = 1'b0;
    logic        sdb = 1'b0;
    logic        req_ack, busy, cs_n, sclk, res_valid;
    logic [11:0] res_a, res_b;
    logic [1:0]  pwr_mode;

    always #5 clk = ~clk;

    adc_frame_seq #(
        .SCLK_HALF (HALF),
        .QUIET_CYC (QC),
        .WAKE_CYC  (WC)
    ) u_adc_frame_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_ack   (req_ack),
        .busy      (busy),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdata_a   (sda),
        .sdata_b   (sdb),
        .res_valid (res_valid),
        .res_a     (res_a),
        .res_b     (res_b),
        .pwr_mode  (pwr_mode)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct { int len; int mingap; string tag; } frm_t;
    typedef struct { logic [11:0] a; logic [11:0] b; string tag; } res_t;
    frm_t frq[$];
    res_t rq[$];

    logic [11:0] wa  = '0;   // line A, clocks 3..14
    logic [11:0] wa2 = '0;   // line A, clocks 19..30
    logic [11:0] wl  = '0;   // line B, clocks 3..14
    int frames_done = 0;
    int exp_pwr = 0;

    // monitor + converter model, all sampled mid-cycle
    int  cyc = 0;
    bit  prev_cs = 1'b1;
    bit  prev_sclk = 1'b1;
    int  k = 0;
    int  cs_fall_cyc = 0;
    int  last_fall = 0;
    int  last_rise = -100000;
    bit  per_ok = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                k = 0;
                cs_fall_cyc = cyc;
                per_ok = 1'b1;
                if (frq.size() == 0)
                    chk(0, "R2 unexpected frame", 1, 0);
                else
                    chk(cyc - last_rise >= frq[0].mingap,
                        (frq[0].mingap == WC) ? "R8 wake gap" : "R9 quiet gap",
                        cyc - last_rise, frq[0].mingap);
            end
            if (!cs_n && prev_sclk && !sclk) begin
                k++;
                if (k == 1) chk(cyc - cs_fall_cyc == HALF, "R3 first fall", cyc - cs_fall_cyc, HALF);
                else if (cyc - last_fall != 2 * HALF) per_ok = 1'b0;
                last_fall = cyc;
                if (k >= 3 && k <= 14)       sda = wa[14 - k];
                else if (k >= 19 && k <= 30) sda = wa2[30 - k];
                else                         sda = 1'b1;
                if (k >= 3 && k <= 14) sdb = wl[14 - k];
                else                   sdb = 1'b1;
            end
            if (!prev_cs && cs_n) begin
                if (frq.size() != 0) begin
                    frm_t f;
                    f = frq.pop_front();
                    chk(k == f.len, f.tag, k, f.len);
                    chk(per_ok, "R3 period", 0, 1);
                end
                last_rise = cyc;
                frames_done++;
            end
            if (res_valid) begin
                if (rq.size() == 0) begin
                    chk(0, "R6 unexpected strobe", 1, 0);
                end else begin
                    res_t r;
                    r = rq.pop_front();
                    chk(res_a == r.a, {r.tag, " res_a"}, res_a, r.a);
                    chk(res_b == r.b, {r.tag, " res_b"}, res_b, r.b);
                end
            end
        end
        prev_cs = cs_n;
        prev_sclk = sclk;
    end

    // driver: queues expectations then raises the request
    task automatic issue(input logic [1:0] op, input logic [11:0] a,
                         input logic [11:0] a2, input logic [11:0] lb);
        int len;
        int target;
        len = (op == 2'b00) ? 14 : (op == 2'b01) ? 16 : (op == 2'b10) ? 32 : 4;
        wa = a; wa2 = a2; wl = lb;
        target = frames_done;
        if (op != 2'b11 && exp_pwr != 0) begin
            frq.push_back('{16, QC, "R8 dummy length"});
            frq.push_back('{len, WC, "R2 length after wake"});
            target += 2;
            exp_pwr = 0;
        end else begin
            frq.push_back('{len, QC, "R2 length"});
            target += 1;
            if (op == 2'b11) exp_pwr = (exp_pwr == 0) ? 1 : 2;
        end
        if (op != 2'b11)
            rq.push_back('{a, (op == 2'b10) ? a2 : lb, (op == 2'b10) ? "R5" : "R4"});
        @(negedge clk);
        req_op = op;
        req_valid = 1'b1;
        forever begin
            #1;
            chk(!(req_ack && busy), "R10 ack while busy", req_ack, 0);
            if (req_ack) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        while (frames_done < target) begin
            @(negedge clk);
            #1;
        end
        chk(pwr_mode == exp_pwr[1:0], (op == 2'b11) ? "R7 mode" : "R8 mode", pwr_mode, exp_pwr);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(sclk == 1'b1, "R1 sclk", sclk, 1);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(req_ack == 1'b0, "R1 req_ack", req_ack, 0);
        chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
        chk(pwr_mode == 2'b00, "R1 pwr_mode", pwr_mode, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        issue(2'b00, 12'hA5C, 12'h000, 12'h3F1);   // R4 14-clock
        issue(2'b01, 12'hFFF, 12'h000, 12'h000);   // R4 16-clock, trailing ones ignored
        issue(2'b10, 12'h123, 12'hEDC, 12'h555);   // R5 dual, line B ignored
        issue(2'b11, 12'h000, 12'h000, 12'h000);   // R7 to partial
        issue(2'b11, 12'h000, 12'h000, 12'h000);   // R7 to full
        issue(2'b11, 12'h000, 12'h000, 12'h000);   // R7 stays full
        issue(2'b01, 12'h6B2, 12'h000, 12'h94D);   // R8 wake then read16
        issue(2'b11, 12'h000, 12'h000, 12'h000);   // R7 partial again
        issue(2'b10, 12'h800, 12'h001, 12'hAAA);   // R8 wake then dual
        issue(2'b00, 12'h001, 12'h000, 12'h800);   // R4 back-to-back after wake

        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(rq.size() == 0, "R6 strobes outstanding", rq.size(), 0);
        chk(frq.size() == 0, "R2 frames outstanding", frq.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule